// File: doc/BRIEF.md
# E1 Basic Frame Alignment Monitor

This block watches a recovered 2.048 Mbit/s E1 bit stream and finds the frame boundary. Each received bit comes with a one-cycle valid strobe. The block slides a seven-bit window over the stream until it sees the alignment word in timeslot 0. It then confirms the candidate over the next two frames before it declares lock. While locked it checks the alignment word on every second frame and counts consecutive errored words. Three errored words in a row drop the lock.

The block reports four things. The first is an active-high "lost" flag, where 0 means aligned. The second is a flag that is high when the last two alignment words checked were both errored. The third is a long-loss (RED) alarm, driven by a timer that counts bits received while alignment is lost. The fourth is the seven alignment bits most recently evaluated. While locked, it also gives the timeslot number and the bit index within the timeslot of the latest received bit.

Bit 1 of timeslot 0 is the first bit on the line. In this document an "alignment word" is bits 2 to 8 of timeslot 0, and its error-free value is 0011011.

Top module: `e1fa_monitor`

## Requirements
- R1: After reset, `frm_lost` is 1, and `fas_err2`, `red_alarm`, `rx_fas_word`, `ts_num` and `ts_bit` are all 0.
- R2: One match of the alignment word 0011011 during the search does not clear `frm_lost`. Alignment is never declared before the full verification sequence has completed.
- R3: The search takes a match at some bit. 256 bits later, the bit that sat 6 bits before that bit's frame position (bit 2 of timeslot 0 in a non-alignment frame) must be 1. 512 bits after the match, the alignment word must appear again. When all three tests pass, `frm_lost` falls in the clock after the bit that completes the second word.
- R4: If the bit-2 test of R3 reads 0, the candidate is dropped and the search resumes with the next bit. `frm_lost` stays 1.
- R5: If the second alignment word of R3 is wrong, the candidate is dropped and the search resumes with the next bit. `frm_lost` stays 1.
- R6: While `frm_lost` is 1, `ts_num` and `ts_bit` are 0. Once locked, they show the position of the latest received bit. The bit that completes an alignment word is at timeslot 0, bit index 7. Each further valid bit adds one, wrapping after bit index 7 and after timeslot 31.
- R7: While locked, one or two consecutive errored alignment words keep the lock. The third consecutive errored word sets `frm_lost` in the clock after its last bit.
- R8: `fas_err2` is 1 after an alignment-word check in lock finds this word and the one before it both errored. It returns to 0 after a check finds an error-free word, and after each new acquisition.
- R9: While locked, the contents of the non-alignment frames, including bit 2 of timeslot 0, have no effect on `frm_lost`.
- R10: `rx_fas_word` (bit 6 = frame bit 2, bit 0 = frame bit 8) takes the seven bits of every alignment word the block evaluates. This includes the word that starts a candidate, the second word of a verification (whether it passes or fails) and each check in lock.
- R11: `red_alarm` sets on the (RED_FRAMES × 256)-th valid bit received while `frm_lost` is 1, counting from the first such bit.
- R12: `red_alarm` clears no later than one clock after `frm_lost` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe: `bit_in` carries a new line bit this cycle |
| bit_in | input | 1 | Recovered E1 data bit |
| frm_lost | output | 1 | 1 = basic frame alignment lost or not yet found |
| fas_err2 | output | 1 | Last two alignment words checked in lock were both errored |
| red_alarm | output | 1 | Alignment has been lost for the timer threshold |
| rx_fas_word | output | 7 | Bits 2..8 of the latest evaluated alignment word |
| ts_num | output | 5 | Timeslot of the latest bit while locked, else 0 |
| ts_bit | output | 3 | Bit index in the timeslot while locked, else 0 |

## Verification
The stream opens with a decoy alignment word in idle fill. The decoy passes the bit-2 test and fails on its second word. A design that skipped the second-word test would lock at a false boundary. A design that skipped the bit-2 test would lock while a later bit-2 = 0 frame is still in verification. Errors are injected in lock as a single error, a pair and a run of three. An off-by-one in the loss count either drops lock after two errors or keeps it after three, and an error-history register that is not cleared leaves `fas_err2` set after a good word. The RED timer is sampled on the bit before and on the bit of its threshold. A bit-2 = 0 frame is sent while locked, where a design that kept testing non-alignment frames would lose lock.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
   // Bits 2..8 of timeslot 0 in an alignment frame, bit 2 in the MSB.
   localparam logic [6:0] FAS_WORD = 7'b0011011;

   typedef enum logic [1:0] {
      ST_HUNT     = 2'd0,
      ST_CHK_NFAS = 2'd1,
      ST_CHK_FAS  = 2'd2,
      ST_LOCKED   = 2'd3
   } align_st_t;
endpackage

// File: rtl/e1fa_bitpos.sv
module e1fa_bitpos #(
   parameter int FRAME_BITS = 256,
   parameter int LOAD_AT    = 7,
   localparam int PW        = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic          load,
   output logic [PW-1:0] pos
);
   generate
      if (LOAD_AT >= FRAME_BITS) begin : g_bad_load
         $error("e1fa_bitpos: LOAD_AT must lie inside the frame");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (load)
         pos <= PW'(LOAD_AT);
      else if (adv)
         pos <= (pos == PW'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
   end
endmodule

// File: rtl/e1fa_align_fsm.sv
module e1fa_align_fsm
   import e1fa_pkg::*;
#(
   parameter int LOSS_ERRS = 3,
   localparam int EW       = $clog2(LOSS_ERRS)
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       adv,        // a new bit has entered word_now
   input  logic       frame_evt,  // this bit lands on timeslot 0, bit index 7
   input  logic [6:0] word_now,   // last seven bits, oldest in the MSB
   output logic       load_pos,
   output logic       lost,
   output logic       cefs,
   output logic [6:0] rx_word
);
   align_st_t     st;
   logic [EW-1:0] err_run;
   logic          prev_err;
   logic          fas_due;
   logic          word_ok;

   generate
      if (LOSS_ERRS < 2) begin : g_bad_loss
         $error("e1fa_align_fsm: LOSS_ERRS must be at least 2");
      end
   endgenerate

   always_comb begin
      word_ok  = (word_now == FAS_WORD);
      load_pos = adv && (st == ST_HUNT) && word_ok;
      lost     = (st != ST_LOCKED);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_HUNT;
         err_run  <= '0;
         prev_err <= 1'b0;
         fas_due  <= 1'b0;
         cefs     <= 1'b0;
         rx_word  <= '0;
      end else begin
         case (st)
            ST_HUNT: if (load_pos) begin
               st      <= ST_CHK_NFAS;
               rx_word <= word_now;
            end
            ST_CHK_NFAS: if (frame_evt)
               st <= word_now[6] ? ST_CHK_FAS : ST_HUNT;
            ST_CHK_FAS: if (frame_evt) begin
               rx_word <= word_now;
               if (word_ok) begin
                  st       <= ST_LOCKED;
                  fas_due  <= 1'b0;
                  err_run  <= '0;
                  prev_err <= 1'b0;
                  cefs     <= 1'b0;
               end else begin
                  st <= ST_HUNT;
               end
            end
            default: if (frame_evt) begin
               fas_due <= !fas_due;
               if (fas_due) begin
                  rx_word <= word_now;
                  if (word_ok) begin
                     err_run  <= '0;
                     prev_err <= 1'b0;
                     cefs     <= 1'b0;
                  end else begin
                     prev_err <= 1'b1;
                     cefs     <= prev_err;
                     if (err_run == EW'(LOSS_ERRS - 1))
                        st <= ST_HUNT;
                     else
                        err_run <= err_run + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   // R10: a fresh lock always shows a clean alignment word.
   a_r10_lock_shows_fas: assert property (@(posedge clk) disable iff (rst)
      $fell(lost) |-> (rx_word == FAS_WORD));

   // R8: the double-error flag can only rise from a locked state.
   a_r8_cefs_from_lock: assert property (@(posedge clk) disable iff (rst)
      $rose(cefs) |-> $past(!lost));

   // R8: a new lock starts with a clear error history.
   a_r8_cefs_clear_on_lock: assert property (@(posedge clk) disable iff (rst)
      $fell(lost) |-> !cefs);
endmodule

// File: rtl/e1fa_red_timer.sv
module e1fa_red_timer #(
   parameter int FRAME_BITS = 256,
   parameter int RED_FRAMES = 800,
   localparam int LIMIT     = RED_FRAMES * FRAME_BITS,
   localparam int CW        = $clog2(LIMIT)
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   input  logic lost,
   output logic red
);
   logic [CW-1:0] cnt;

   generate
      if (RED_FRAMES < 1) begin : g_bad_red
         $error("e1fa_red_timer: RED_FRAMES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || !lost) begin
         cnt <= '0;
         red <= 1'b0;
      end else if (adv && !red) begin
         if (cnt == CW'(LIMIT - 1))
            red <= 1'b1;
         else
            cnt <= cnt + 1'b1;
      end
   end

   // R11: the alarm only rises while alignment is lost.
   a_r11_red_needs_loss: assert property (@(posedge clk) disable iff (rst)
      $rose(red) |-> lost);

   // R12: the alarm is gone one clock after alignment returns.
   a_r12_red_drops: assert property (@(posedge clk) disable iff (rst)
      $fell(lost) |=> !red);
endmodule

// File: rtl/e1fa_monitor.sv
module e1fa_monitor #(
   parameter int TS_BITS    = 8,
   parameter int NUM_TS     = 32,
   parameter int RED_FRAMES = 800,
   parameter int LOSS_ERRS  = 3,
   localparam int FRAME_BITS = TS_BITS * NUM_TS,
   localparam int PW         = $clog2(FRAME_BITS),
   localparam int TSW        = $clog2(NUM_TS),
   localparam int TBW        = $clog2(TS_BITS)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           bit_vld,
   input  logic           bit_in,
   output logic           frm_lost,
   output logic           fas_err2,
   output logic           red_alarm,
   output logic [6:0]     rx_fas_word,
   output logic [TSW-1:0] ts_num,
   output logic [TBW-1:0] ts_bit
);
   generate
      if (TS_BITS != 8) begin : g_bad_ts_bits
         $error("e1fa_monitor: the alignment word needs 8-bit timeslots");
      end
      if ((NUM_TS < 2) || ((1 << TSW) != NUM_TS)) begin : g_bad_num_ts
         $error("e1fa_monitor: NUM_TS must be a power of two");
      end
   endgenerate

   logic [6:0]    win_q;
   logic [6:0]    win_nxt;
   logic [PW-1:0] pos;
   logic          load_pos;
   logic          frame_evt;

   assign win_nxt   = {win_q[5:0], bit_in};
   assign frame_evt = bit_vld && (pos == PW'(TS_BITS - 2));

   always_ff @(posedge clk) begin
      if (rst)
         win_q <= '0;
      else if (bit_vld)
         win_q <= win_nxt;
   end

   e1fa_bitpos #(
      .FRAME_BITS (FRAME_BITS),
      .LOAD_AT    (TS_BITS - 1)
   ) u_bitpos (
      .clk  (clk),
      .rst  (rst),
      .adv  (bit_vld),
      .load (load_pos),
      .pos  (pos)
   );

   e1fa_align_fsm #(
      .LOSS_ERRS (LOSS_ERRS)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .adv       (bit_vld),
      .frame_evt (frame_evt),
      .word_now  (win_nxt),
      .load_pos  (load_pos),
      .lost      (frm_lost),
      .cefs      (fas_err2),
      .rx_word   (rx_fas_word)
   );

   e1fa_red_timer #(
      .FRAME_BITS (FRAME_BITS),
      .RED_FRAMES (RED_FRAMES)
   ) u_red (
      .clk  (clk),
      .rst  (rst),
      .adv  (bit_vld),
      .lost (frm_lost),
      .red  (red_alarm)
   );

   assign ts_num = frm_lost ? '0 : pos[PW-1 -: TSW];
   assign ts_bit = frm_lost ? '0 : pos[TBW-1:0];

   // R3: lock is declared on the last bit of timeslot 0.
   a_r3_lock_at_ts0_end: assert property (@(posedge clk) disable iff (rst)
      $fell(frm_lost) |-> (pos == PW'(TS_BITS - 1)));

   // R6: while locked, every valid bit moves the bit index forward by one.
   a_r6_bit_index_steps: assert property (@(posedge clk) disable iff (rst)
      (!frm_lost && $past(!frm_lost) && $past(bit_vld))
         |-> (ts_bit == $past(ts_bit) + TBW'(1)));

   // R6: position outputs rest at zero while unaligned.
   a_r6_pos_zero_unlocked: assert property (@(posedge clk) disable iff (rst)
      frm_lost |-> (ts_num == '0 && ts_bit == '0));
endmodule

// File: tb/e1fa_monitor_tb.sv
`timescale 1ns/1ps
module e1fa_monitor_tb;
   localparam int RED_FR   = 3;
   localparam int N_BITS   = 6800;
   localparam int WDOG_CYC = 200000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_vld = 1'b0;
   logic       bit_in = 1'b0;
   logic       frm_lost, fas_err2, red_alarm;
   logic [6:0] rx_fas_word;
   logic [4:0] ts_num;
   logic [2:0] ts_bit;

   always #2.5 clk = ~clk;

   e1fa_monitor #(.RED_FRAMES(RED_FR)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .bit_vld     (bit_vld),
      .bit_in      (bit_in),
      .frm_lost    (frm_lost),
      .fas_err2    (fas_err2),
      .red_alarm   (red_alarm),
      .rx_fas_word (rx_fas_word),
      .ts_num      (ts_num),
      .ts_bit      (ts_bit)
   );

   typedef struct {
      int         idx;
      int         fld;   // 0 lost, 1 err2, 2 red, 3 word, 4 ts, 5 bit
      logic [6:0] val;
      string      req;
   } exp_t;

   exp_t  sb_q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    done_idx = -1;
   bit    finished = 1'b0;
   event  bit_done;

   task automatic push(input int idx, input int fld, input logic [6:0] val,
                       input string req);
      exp_t e;
      e.idx = idx; e.fld = fld; e.val = val; e.req = req;
      sb_q.push_back(e);
   endtask

   function automatic logic [6:0] field(input int fld);
      case (fld)
         0: return {6'd0, frm_lost};
         1: return {6'd0, fas_err2};
         2: return {6'd0, red_alarm};
         3: return rx_fas_word;
         4: return {2'd0, ts_num};
         default: return {4'd0, ts_bit};
      endcase
   endfunction

   task automatic check(input string req, input logic [6:0] act,
                        input logic [6:0] exp, input int idx);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at bit %0d: actual %b expected %b", req, idx, act, exp);
      end
   endtask

   // Line model: 100 fill bits with a decoy word, then frames from bit 100.
   function automatic logic tx_bit(input int k);
      int f, p;
      logic [6:0] w;
      if (k < 100) begin
         if (k >= 44 && k <= 50) begin
            w = 7'b0011011;
            return w[6 - (k - 44)];
         end
         return 1'b1;
      end
      f = (k - 100) / 256;
      p = (k - 100) % 256;
      if (p == 0 || p >= 8) return 1'b1;
      if (f % 2 == 0) begin
         if (f == 6 || f == 10 || f == 12 || f == 16 || f == 18 || f == 20)
            w = 7'b0111011;
         else
            w = 7'b0011011;
         return w[7 - p];
      end
      if (p == 1) return (f == 15 || f == 23) ? 1'b0 : 1'b1;
      return 1'b1;
   endfunction

   // Monitor: compares scoreboard entries due on the bit just finished.
   always @(bit_done) begin
      while (sb_q.size() > 0 && sb_q[0].idx == done_idx) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.req, field(e.fld), e.val, e.idx);
      end
   end

   initial begin : watchdog
      repeat (WDOG_CYC) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : driver
      // Expected outputs, indexed by the bit after which they are sampled.
      push(50,   0, 7'd1, "R2");
      push(562,  0, 7'd1, "R5");   push(562, 3, 7'b1111111, "R10");
      push(700,  0, 7'd1, "R5");   push(700, 4, 7'd0, "R6");  push(700, 5, 7'd0, "R6");
      push(766,  2, 7'd0, "R11");  push(767, 2, 7'd1, "R11");
      push(1130, 0, 7'd1, "R2");
      push(1131, 0, 7'd0, "R3");   push(1131, 3, 7'b0011011, "R10");
      push(1131, 4, 7'd0, "R6");   push(1131, 5, 7'd7, "R6");
      push(1131, 1, 7'd0, "R8");   push(1131, 2, 7'd0, "R12");
      push(1172, 4, 7'd6, "R6");   push(1172, 5, 7'd0, "R6");
      push(1643, 3, 7'b0111011, "R10"); push(1643, 0, 7'd0, "R7"); push(1643, 1, 7'd0, "R8");
      push(2155, 3, 7'b0011011, "R10");
      push(2667, 1, 7'd0, "R8");
      push(3179, 1, 7'd1, "R8");   push(3179, 0, 7'd0, "R7");
      push(3691, 1, 7'd0, "R8");
      push(3947, 0, 7'd0, "R9");
      push(4203, 1, 7'd0, "R8");
      push(4715, 1, 7'd1, "R8");   push(4715, 0, 7'd0, "R7");
      push(5226, 0, 7'd0, "R7");
      push(5227, 0, 7'd1, "R7");   push(5227, 1, 7'd1, "R8");
      push(5739, 0, 7'd1, "R2");
      push(5994, 2, 7'd0, "R11");  push(5995, 2, 7'd1, "R11");
      push(6300, 0, 7'd1, "R4");
      push(6762, 0, 7'd1, "R4");   push(6762, 2, 7'd1, "R11");
      push(6763, 0, 7'd0, "R3");   push(6763, 2, 7'd0, "R12");
      push(6763, 3, 7'b0011011, "R10"); push(6763, 1, 7'd0, "R8");

      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check("R1", {6'd0, frm_lost},  7'd1, -1);
      check("R1", {6'd0, fas_err2},  7'd0, -1);
      check("R1", {6'd0, red_alarm}, 7'd0, -1);
      check("R1", rx_fas_word,       7'd0, -1);
      check("R1", {2'd0, ts_num},    7'd0, -1);
      check("R1", {4'd0, ts_bit},    7'd0, -1);

      for (int k = 0; k < N_BITS; k++) begin
         bit_in  = tx_bit(k);
         bit_vld = 1'b1;
         @(negedge clk);
         bit_vld = 1'b0;
         repeat (3) @(negedge clk);
         done_idx = k;
         -> bit_done;
         #0.1;
      end

      if (sb_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: actual %0d entries left expected 0", sb_q.size());
      end
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule